// File: doc/BRIEF.md
# Cartridge Bank-Switching Memory Mapper

This block sits on a cartridge between an 8-bit CPU bus, a video pattern-fetch bus and the external program and pattern memories. CPU stores into a sixteen-byte register window program the bank selections, a single-screen page bit and a lock byte. A 256-byte internal work RAM is reachable only while that lock byte holds one exact key value.

CPU addresses from 0x8000 upward are translated into program-memory addresses through four 8 KB windows. The top window is pinned to the last bank. Video addresses below 0x2000 are translated into pattern-memory addresses. The lower half of that range uses two 2 KB windows and the upper half uses four 1 KB windows. A build without pattern ROM instead passes video addresses straight through to an 8 KB pattern RAM and lets video writes reach it. All translation is combinational from the current register contents.

Top module: `bank_mapper`

## Requirements
- R1: After reset the three program selectors hold 0, 1 and 2, the six pattern selectors hold 0, the page bit is 0, and the lock byte holds 0xFF, so work-RAM reads return 0xFF.
- R2: A CPU write to 0x7EF0+n, for n from 0 to 5, loads pattern selector n with the data byte.
- R3: A CPU write to 0x7EF6 sets the page output `ntPage` to data bit 0.
- R4: Writes to 0x7EFA or 0x7EFB load program selector 0, writes to 0x7EFC or 0x7EFD load selector 1, and writes to 0x7EFE or 0x7EFF load selector 2. Writes to 0x7EF7 and 0x7EF9, and writes at or above 0x8000, change no output.
- R5: A CPU address in 0xE000–0xFFFF maps to bank PROG_BANKS-1 at offset addr[12:0].
- R6: CPU addresses in 0x8000–0x9FFF, 0xA000–0xBFFF and 0xC000–0xDFFF use program selectors 0, 1 and 2. The bank is (selector mod PROG_BANKS), and `progAddr` = bank*8192 + addr[12:0].
- R7: The work RAM at 0x7F00–0x7FFF is indexed by addr[7:0]. It reads and writes only while the lock byte, written at 0x7EF8, equals 0xA3. Otherwise reads give 0xFF and writes leave the contents unchanged.
- R8: For video addresses 0x0000–0x07FF and 0x0800–0x0FFF, pattern selectors 0 and 1 give a 2 KB bank b = ((sel >> 1) & 0x3F) mod (PAT_KB_BANKS/2), and `patAddr` = b*2048 + addr[10:0].
- R9: For video addresses 0x1000–0x1FFF, the 1 KB window k = addr[11:10] uses pattern selector 2+k. The bank is b = sel mod PAT_KB_BANKS, and `patAddr` = b*1024 + addr[9:0].
- R10: Built without pattern ROM (PAT_ROM=0), `patAddr` equals video addr[12:0] and `patWe` follows `vidWe` for video addresses below 0x2000. Built with pattern ROM, `patWe` stays 0.
- R11: `cpuClaim` is 1 for any address at or above 0x8000 and for 0x7F00–0x7FFF. It is also 1 for 0x7EF0–0x7EFF while `cpuWe` is 1. Otherwise it is 0.
- R12: Registers change only at a rising clock edge with `cpuWe` high. Before that edge the outputs still show the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cpuAddr | input | 16 | CPU address |
| cpuDin | input | 8 | CPU write data |
| cpuWe | input | 1 | CPU write strobe |
| cpuClaim | output | 1 | Block decodes this CPU access |
| cpuRdData | output | 8 | Work-RAM read data, 0xFF when locked |
| progAddr | output | $clog2(PROG_BANKS)+13 | Program-memory address |
| vidAddr | input | 14 | Video fetch address |
| vidWe | input | 1 | Video write strobe |
| patAddr | output | $clog2(PAT_KB_BANKS)+10 | Pattern-memory address |
| patSel | output | 1 | Video address lies in pattern space |
| patWe | output | 1 | Write enable to pattern RAM |
| ntPage | output | 1 | Single-screen page select |

## Verification
The bench builds two copies side by side on the same CPU bus. The first uses the defaults: 16 program banks, 64 one-kilobyte pattern banks and pattern ROM fitted. Its 8-bit selectors wrap through the program modulo, and the 2 KB windows hit the 0x3F mask and then the 32-bank fold. The second uses 4 program banks and no pattern ROM. That build reaches the last-bank pin at a different bank value, plus the pass-through pattern RAM path and its write enable.

// File: rtl/bank_mapper_pkg.sv
`timescale 1ns/1ps
package bank_mapper_pkg;

  localparam logic [7:0]  GATE_KEY  = 8'hA3;
  localparam logic [11:0] REG_PAGE  = 12'h7EF;
  localparam logic [7:0]  RAM_PAGE  = 8'h7F;

  typedef struct packed {
    logic [5:0] patLd;
    logic       ntLd;
    logic       gateLd;
    logic [2:0] progLd;
    logic       ramWr;
  } mapStrobe_t;

endpackage

// File: rtl/bank_mapper_ctrl.sv
`timescale 1ns/1ps
module bank_mapper_ctrl
  import bank_mapper_pkg::*;
(
  input  logic [15:0] cpuAddr,
  input  logic        cpuWe,
  input  logic        ramOpen,
  output mapStrobe_t  strobe,
  output logic        ramHit,
  output logic        cpuClaim
);

  logic inRegWin;
  logic inRom;

  assign inRegWin = (cpuAddr[15:4] == REG_PAGE);
  assign ramHit   = (cpuAddr[15:8] == RAM_PAGE);
  assign inRom    = cpuAddr[15];

  always_comb begin
    strobe = '0;
    if (cpuWe && inRegWin) begin
      case (cpuAddr[3:0])
        4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5:
          strobe.patLd[cpuAddr[2:0]] = 1'b1;
        4'h6:        strobe.ntLd      = 1'b1;
        4'h8:        strobe.gateLd    = 1'b1;
        4'hA, 4'hB:  strobe.progLd[0] = 1'b1;
        4'hC, 4'hD:  strobe.progLd[1] = 1'b1;
        4'hE, 4'hF:  strobe.progLd[2] = 1'b1;
        default:     strobe = '0;
      endcase
    end
    strobe.ramWr = cpuWe && ramHit && ramOpen;
  end

  assign cpuClaim = inRom || ramHit || (cpuWe && inRegWin);

endmodule

// File: rtl/bank_mapper_dp.sv
`timescale 1ns/1ps
module bank_mapper_dp
  import bank_mapper_pkg::*;
#(
  parameter int PROG_BANKS   = 16,
  parameter int PAT_KB_BANKS = 64,
  parameter bit PAT_ROM      = 1'b1,
  localparam int PROG_AW     = $clog2(PROG_BANKS) + 13,
  localparam int PAT_AW      = $clog2(PAT_KB_BANKS) + 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapStrobe_t        strobe,
  input  logic [7:0]        cpuDin,
  input  logic [1:0]        cpuWin,
  input  logic [12:0]       cpuLow,
  input  logic              ramHit,
  input  logic [13:0]       vidAddr,
  input  logic              vidWe,
  output logic              ramOpen,
  output logic [7:0]        cpuRdData,
  output logic [PROG_AW-1:0] progAddr,
  output logic [PAT_AW-1:0] patAddr,
  output logic              patSel,
  output logic              patWe,
  output logic              ntPage
);

  localparam logic [7:0] PROG_MASK = 8'(PROG_BANKS - 1);
  localparam logic [7:0] KB_MASK   = 8'(PAT_KB_BANKS - 1);
  localparam int         NUM_PAT   = 6;
  localparam int         NUM_PROG  = 3;
  localparam int         RAM_DEPTH = 256;

  logic [7:0] patReg  [NUM_PAT];
  logic [7:0] progReg [NUM_PROG];
  logic [7:0] gateReg;
  logic       ntReg;
  logic [7:0] wram [RAM_DEPTH];

  // Selector registers
  for (genvar i = 0; i < NUM_PAT; i++) begin : g_pat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                patReg[i] <= '0;
      else if (strobe.patLd[i]) patReg[i] <= cpuDin;
    end
  end

  for (genvar j = 0; j < NUM_PROG; j++) begin : g_prog
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 progReg[j] <= 8'(j);
      else if (strobe.progLd[j]) progReg[j] <= cpuDin;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateReg <= 8'hFF;
      ntReg   <= 1'b0;
    end else begin
      if (strobe.gateLd) gateReg <= cpuDin;
      if (strobe.ntLd)   ntReg   <= cpuDin[0];
    end
  end

  // Work RAM
  always_ff @(posedge clk) begin
    if (strobe.ramWr) wram[cpuLow[7:0]] <= cpuDin;
  end

  assign ramOpen   = (gateReg == GATE_KEY);
  assign cpuRdData = (ramHit && ramOpen) ? wram[cpuLow[7:0]] : 8'hFF;
  assign ntPage    = ntReg;

  // Program translation
  logic [7:0] progBank;
  always_comb begin
    case (cpuWin)
      2'd0:    progBank = progReg[0] & PROG_MASK;
      2'd1:    progBank = progReg[1] & PROG_MASK;
      2'd2:    progBank = progReg[2] & PROG_MASK;
      default: progBank = PROG_MASK;
    endcase
  end
  assign progAddr = PROG_AW'({progBank, cpuLow});

  // Pattern translation
  logic [7:0]        kbBank;
  logic [PAT_AW-1:0] romAddr;
  logic [PAT_AW-1:0] ramAddr;

  function automatic logic [7:0] twoKbToKb(input logic [7:0] sel, input logic half);
    return (((sel >> 1) & 8'h3F) << 1) | {7'b0, half};
  endfunction

  always_comb begin
    case (vidAddr[12:10])
      3'd0, 3'd1: kbBank = twoKbToKb(patReg[0], vidAddr[10]) & KB_MASK;
      3'd2, 3'd3: kbBank = twoKbToKb(patReg[1], vidAddr[10]) & KB_MASK;
      3'd4:       kbBank = patReg[2] & KB_MASK;
      3'd5:       kbBank = patReg[3] & KB_MASK;
      3'd6:       kbBank = patReg[4] & KB_MASK;
      default:    kbBank = patReg[5] & KB_MASK;
    endcase
  end

  assign romAddr = PAT_AW'({kbBank, vidAddr[9:0]});
  assign ramAddr = PAT_AW'(vidAddr[12:0]);
  assign patAddr = PAT_ROM ? romAddr : ramAddr;
  assign patSel  = !vidAddr[13];
  assign patWe   = !PAT_ROM && vidWe && !vidAddr[13];

endmodule

// File: rtl/bank_mapper.sv
`timescale 1ns/1ps
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int PROG_BANKS   = 16,
  parameter int PAT_KB_BANKS = 64,
  parameter bit PAT_ROM      = 1'b1,
  localparam int PROG_AW     = $clog2(PROG_BANKS) + 13,
  localparam int PAT_AW      = $clog2(PAT_KB_BANKS) + 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [15:0]        cpuAddr,
  input  logic [7:0]         cpuDin,
  input  logic               cpuWe,
  output logic               cpuClaim,
  output logic [7:0]         cpuRdData,
  output logic [PROG_AW-1:0] progAddr,
  input  logic [13:0]        vidAddr,
  input  logic               vidWe,
  output logic [PAT_AW-1:0]  patAddr,
  output logic               patSel,
  output logic               patWe,
  output logic               ntPage
);

  mapStrobe_t strobe;
  logic       ramHit;
  logic       ramOpen;

  bank_mapper_ctrl u_ctrl (
    .cpuAddr (cpuAddr),
    .cpuWe   (cpuWe),
    .ramOpen (ramOpen),
    .strobe  (strobe),
    .ramHit  (ramHit),
    .cpuClaim(cpuClaim)
  );

  bank_mapper_dp #(
    .PROG_BANKS  (PROG_BANKS),
    .PAT_KB_BANKS(PAT_KB_BANKS),
    .PAT_ROM     (PAT_ROM)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cpuDin   (cpuDin),
    .cpuWin   (cpuAddr[14:13]),
    .cpuLow   (cpuAddr[12:0]),
    .ramHit   (ramHit),
    .vidAddr  (vidAddr),
    .vidWe    (vidWe),
    .ramOpen  (ramOpen),
    .cpuRdData(cpuRdData),
    .progAddr (progAddr),
    .patAddr  (patAddr),
    .patSel   (patSel),
    .patWe    (patWe),
    .ntPage   (ntPage)
  );

endmodule

// File: rtl/bank_mapper_chk.sv
`timescale 1ns/1ps
module bank_mapper_chk
  import bank_mapper_pkg::*;
#(
  parameter int PROG_BANKS = 16,
  parameter bit PAT_ROM    = 1'b1,
  localparam int PROG_AW   = $clog2(PROG_BANKS) + 13
) (
  input logic               clk,
  input logic               rstN,
  input logic [15:0]        cpuAddr,
  input logic [7:0]         cpuDin,
  input logic               cpuWe,
  input logic               cpuClaim,
  input logic [7:0]         cpuRdData,
  input logic [PROG_AW-1:0] progAddr,
  input logic               vidWe,
  input logic               patWe,
  input logic               ntPage,
  input logic               ramOpen,
  input mapStrobe_t         strobe
);

  localparam int PBW = PROG_AW - 13;

  // R4: at most one load strobe per cycle
  p_single_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  p_locked_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:8] == RAM_PAGE && !ramOpen) |-> cpuRdData == 8'hFF);

  p_lock_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && cpuAddr == 16'h7EF8 && cpuDin != GATE_KEY) |=> !ramOpen);

  p_last_bank_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:13] == 3'b111) |-> progAddr[PROG_AW-1:13] == PBW'(PROG_BANKS - 1));

  p_page_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && cpuAddr == 16'h7EF6) |=> ntPage == $past(cpuDin[0]));

  p_rom_claim_r11: assert property (@(posedge clk) disable iff (!rstN)
    cpuAddr[15] |-> cpuClaim);

  p_rom_no_vwrite_r10: assert property (@(posedge clk) disable iff (!rstN)
    (PAT_ROM && vidWe) |-> !patWe);

endmodule

bind bank_mapper bank_mapper_chk #(
  .PROG_BANKS(PROG_BANKS),
  .PAT_ROM   (PAT_ROM)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuAddr  (cpuAddr),
  .cpuDin   (cpuDin),
  .cpuWe    (cpuWe),
  .cpuClaim (cpuClaim),
  .cpuRdData(cpuRdData),
  .progAddr (progAddr),
  .vidWe    (vidWe),
  .patWe    (patWe),
  .ntPage   (ntPage),
  .ramOpen  (ramOpen),
  .strobe   (strobe)
);

// File: tb/bank_mapper_bench.sv
`timescale 1ns/1ps
module bank_mapper_bench;

  localparam int A_PROG = 16;
  localparam int A_KB   = 64;
  localparam int B_PROG = 4;
  localparam int B_KB   = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuDin = '0;
  logic        cpuWe = 1'b0;
  logic [13:0] vidAddr = '0;
  logic        vidWe = 1'b0;

  logic        claimA, claimB, pselA, pselB, pweA, pweB, ntA, ntB;
  logic [7:0]  rdA, rdB;
  logic [16:0] progA;
  logic [14:0] progB;
  logic [15:0] patA;
  logic [12:0] patB;

  always #10 clk = ~clk;

  bank_mapper u_bank_mapper (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuDin(cpuDin), .cpuWe(cpuWe),
    .cpuClaim(claimA), .cpuRdData(rdA), .progAddr(progA),
    .vidAddr(vidAddr), .vidWe(vidWe), .patAddr(patA), .patSel(pselA),
    .patWe(pweA), .ntPage(ntA)
  );

  bank_mapper #(.PROG_BANKS(B_PROG), .PAT_KB_BANKS(B_KB), .PAT_ROM(1'b0)) u_bank_mapper_ram (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuDin(cpuDin), .cpuWe(cpuWe),
    .cpuClaim(claimB), .cpuRdData(rdB), .progAddr(progB),
    .vidAddr(vidAddr), .vidWe(vidWe), .patAddr(patB), .patSel(pselB),
    .patWe(pweB), .ntPage(ntB)
  );

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  int patM [6];
  int progM [3];
  int gateM;
  int ntM;
  int ramM [256];

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expProg(input logic [15:0] a, input int nb);
    int win = int'(a[14:13]);
    int bank = (win == 3) ? nb - 1 : progM[win] % nb;
    return bank * 8192 + int'(a[12:0]);
  endfunction

  function automatic int expPat(input logic [13:0] v);
    int b;
    if (!v[12]) begin
      b = ((patM[v[11]] >> 1) & 63) % (A_KB / 2);
      return b * 2048 + int'(v[10:0]);
    end
    b = patM[2 + int'(v[11:10])] % A_KB;
    return b * 1024 + int'(v[9:0]);
  endfunction

  function automatic bit expClaim(input logic [15:0] a, input bit we);
    return a[15] || (a[15:8] == 8'h7F) || (we && a[15:4] == 12'h7EF);
  endfunction

  task automatic modelWrite(input logic [15:0] a, input logic [7:0] d);
    if (a[15:4] == 12'h7EF) begin
      case (a[3:0])
        4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5: patM[a[2:0]] = int'(d);
        4'h6: ntM = int'(d[0]);
        4'h8: gateM = int'(d);
        4'hA, 4'hB: progM[0] = int'(d);
        4'hC, 4'hD: progM[1] = int'(d);
        4'hE, 4'hF: progM[2] = int'(d);
        default: ;
      endcase
    end else if (a[15:8] == 8'h7F && gateM == 8'hA3) begin
      ramM[a[7:0]] = int'(d);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuDin = d; cpuWe = 1'b1;
    #3;
    chk("R11 write claim", int'(claimA), int'(expClaim(a, 1'b1)));
    chk("R12 before edge", int'(ntA), ntM);
    @(posedge clk);
    #1;
    cpuWe = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic probeAll();
    logic [15:0] a;
    logic [13:0] v;
    for (int w = 0; w < 4; w++) begin
      a = {1'b1, 2'(w), 13'($urandom())};
      cpuAddr = a; #1;
      chk(w == 3 ? "R5 fixed last A" : "R6 banked A", int'(progA), expProg(a, A_PROG));
      chk(w == 3 ? "R5 fixed last B" : "R6 banked B", int'(progB), expProg(a, B_PROG));
    end
    for (int w = 0; w < 8; w++) begin
      v = {1'b0, 3'(w), 10'($urandom())};
      vidAddr = v; #1;
      chk(w < 4 ? "R8 2K window" : "R9 1K window", int'(patA), expPat(v));
      chk("R10 direct pattern RAM", int'(patB), int'(v[12:0]));
    end
    chk("R3 page A", int'(ntA), ntM);
    chk("R3 page B", int'(ntB), ntM);
    a = {8'h7F, 8'($urandom())};
    cpuAddr = a; #1;
    chk("R7 ram read", int'(rdA), (gateM == 8'hA3) ? ramM[a[7:0]] : 8'hFF);
    chk("R7 ram read B", int'(rdB), (gateM == 8'hA3) ? ramM[a[7:0]] : 8'hFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    int seedVal;
    logic [15:0] a;
    logic [7:0]  d;
    seedVal = int'($urandom(32'd20250611));
    for (int i = 0; i < 6; i++) patM[i] = 0;
    for (int i = 0; i < 3; i++) progM[i] = i;
    gateM = 8'hFF; ntM = 0;
    for (int i = 0; i < 256; i++) ramM[i] = 0;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    cpuAddr = 16'h8123; #1; chk("R1 prog sel0", int'(progA), 16'h0123);
    cpuAddr = 16'hA123; #1; chk("R1 prog sel1", int'(progA), 16'h2123);
    cpuAddr = 16'hC123; #1; chk("R1 prog sel2", int'(progA), 16'h4123);
    cpuAddr = 16'h7F40; #1; chk("R1 locked read", int'(rdA), 8'hFF);
    vidAddr = 14'h1C05; #1; chk("R1 pattern sel5", int'(patA), 16'h0005);
    chk("R1 page", int'(ntA), 0);

    // R7: fill RAM while unlocked
    wr(16'h7EF8, 8'hA3);
    for (int i = 0; i < 256; i++) wr({8'h7F, 8'(i)}, 8'(i * 7 + 3));
    cpuAddr = 16'h7F10; #1; chk("R7 unlocked read", int'(rdA), ramM[16]);
    wr(16'h7EF8, 8'hA2);
    cpuAddr = 16'h7F10; #1; chk("R7 near-key locks", int'(rdA), 8'hFF);
    wr(16'h7F10, 8'h55);
    wr(16'h7EF8, 8'hA3);
    cpuAddr = 16'h7F10; #1; chk("R7 locked write dropped", int'(rdA), ramM[16]);

    // R2 and R8/R9 corner values
    wr(16'h7EF0, 8'hFF);
    wr(16'h7EF1, 8'h01);
    wr(16'h7EF2, 8'hFF);
    vidAddr = 14'h0000; #1; chk("R8 sel 0xFF folds", int'(patA), 31 * 2048);
    vidAddr = 14'h0801; #1; chk("R8 bit0 ignored", int'(patA), 1);
    vidAddr = 14'h1002; #1; chk("R9 1K modulo", int'(patA), 63 * 1024 + 2);
    probeAll();

    // R4: register pairs and ignored addresses
    wr(16'h7EFB, 8'h0B);
    cpuAddr = 16'h8000; #1; chk("R4 pair alias", int'(progA), 11 * 8192);
    wr(16'h7EFD, 8'hF7);
    cpuAddr = 16'hA000; #1; chk("R6 modulo", int'(progA), 7 * 8192);
    cpuAddr = 16'hE000; #1; chk("R5 last bank B", int'(progB), 3 * 8192);
    wr(16'h7EF7, 8'h5A);
    wr(16'h7EF9, 8'hA5);
    wr(16'h9000, 8'h11);
    probeAll();

    // R3
    wr(16'h7EF6, 8'hFF); probeAll();
    wr(16'h7EF6, 8'hFE); probeAll();

    // Random mix
    for (int n = 0; n < 400; n++) begin
      case ($urandom_range(9))
        0, 1, 2, 3, 4, 5, 6: a = {12'h7EF, 4'($urandom())};
        7, 8: a = {8'h7F, 8'($urandom())};
        default: a = 16'($urandom());
      endcase
      d = 8'($urandom());
      if (a == 16'h7EF8 && $urandom_range(1) == 0) d = 8'hA3;
      wr(a, d);
      probeAll();
    end

    // R11: read-side claim
    for (int n = 0; n < 64; n++) begin
      a = 16'($urandom());
      if (n % 4 == 0) a = {12'h7EF, 4'($urandom())};
      cpuAddr = a; #1;
      chk("R11 read claim", int'(claimA), int'(expClaim(a, 1'b0)));
    end

    // R10: video write enable
    vidAddr = 14'h0ABC; vidWe = 1'b1; #1;
    chk("R10 RAM build write", int'(pweB), 1);
    chk("R10 ROM build no write", int'(pweA), 0);
    chk("R10 pattern select", int'(pselB), 1);
    vidAddr = 14'h2ABC; #1;
    chk("R10 outside range", int'(pweB), 0);
    chk("R10 outside select", int'(pselA), 0);
    vidWe = 1'b0; #1;
    vidAddr = 14'h0ABC; #1;
    chk("R10 idle", int'(pweB), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule